// File: doc/BRIEF.md
# Four-Way Instruction Cache Controller

This block is a read-only instruction cache placed between a processor's instruction-fetch port and a word-wide main-memory read port. It holds 8 KB of instructions as 64 sets of four 32-byte lines. A fetch that hits returns its word in the same cycle it is requested, with no wait states. A fetch that misses starts a whole-line refill. The refill begins with the requested word, which goes to the processor the moment it arrives, and continues through the rest of the line in wrapping order. Victims are chosen by least-recently-used order within the set.

Software has two controls. A lock input freezes the contents: misses are then served by a single pass-through memory read and nothing is allocated or evicted. A separate write port stores words straight into lines that are already resident. An invalidate input drops every line in one cycle. Tag, valid, age and data storage are behavioural registers.

Top module: `icache_ctrl`

## Requirements
- R1: When `fetch_req` is high, the block is idle and the addressed line is resident, `fetch_ready` is high in that same cycle and `fetch_rdata` carries the stored word. No memory read is issued.
- R2: The fetch address is split as follows: bits [1:0] are the byte offset, [4:2] the word in the line, [10:5] the set and [31:11] the tag. A miss issues eight word reads. Each read uses the line base of the missed address, and the word index runs crit, crit+1, ... modulo 8. Every `mem_addr` has bits [1:0] equal to zero.
- R3: During a refill, `fetch_ready` is raised exactly once, in the cycle the first (requested) word has `mem_rvalid` high, with `fetch_rdata` equal to `mem_rdata`.
- R4: Once a refill has completed, every one of the line's eight words hits.
- R5: A refill into a full set replaces the line least recently hit or filled in that set.
- R6: While `lock_en` is high, hits are still served, but a miss causes exactly one memory read of the requested word. That word is passed through, and no line is allocated or evicted.
- R7: A `wr_en` write to a resident word changes what later fetches of it return. A write to a non-resident address has no effect. A hit and a write to the same word in the same cycle return the old word.
- R8: After a cycle with `inv_all` high, every address misses.
- R9: After reset, all lines are invalid and `mem_req` and `fetch_ready` are low.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` is seen, and each cycle with both high completes one word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Invalidate every line |
| lock_en | input | 1 | Freeze cache contents |
| fetch_req | input | 1 | Instruction fetch request, held until ready |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_rdata | output | 32 | Fetched instruction word |
| mem_req | output | 1 | Main-memory word read request |
| mem_addr | output | 32 | Main-memory word address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| wr_en | input | 1 | Direct cache write strobe |
| wr_addr | input | 32 | Direct write byte address |
| wr_data | input | 32 | Direct write data |

## Verification
A fetch hit and a direct write can fall in the same cycle on the same word. The read must see the old contents, and the new contents must appear from the following fetch on. The bench provokes this by raising `wr_en` together with a hitting `fetch_req` to the same address. It judges the returned word against a model that applies the write only after the fetch has been answered. It then fetches the word again and expects the written value.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PASS = 2'd2
  } ic_state_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int WAYS  = 4,
  parameter int SETS  = 64,
  parameter int TAG_W = 21,
  parameter int SET_W = 6,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way,
  input  logic [SET_W-1:0] pw_set,
  input  logic [TAG_W-1:0] pw_tag,
  output logic             pw_hit,
  output logic [WAY_W-1:0] pw_way,
  input  logic             clr_en,
  input  logic [WAY_W-1:0] clr_way,
  input  logic [SET_W-1:0] clr_set,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [SETS-1:0]  vld_q [WAYS];
  logic [WAYS-1:0]  lk_vec, pw_vec;

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
    end else begin
      if (clr_en)  vld_q[clr_way][clr_set]   <= 1'b0;
      if (fill_en) vld_q[fill_way][fill_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_way][fill_set] <= fill_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_vec[w] = vld_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);
    assign pw_vec[w] = vld_q[w][pw_set] && (tag_q[w][pw_set] == pw_tag);
  end

  always_comb begin
    lk_way = '0;
    pw_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_vec[w]) lk_way = WAY_W'(w);
      if (pw_vec[w]) pw_way = WAY_W'(w);
    end
  end

  assign lk_hit = |lk_vec;
  assign pw_hit = |pw_vec;
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int WAYS  = 4,
  parameter int SETS  = 64,
  parameter int SET_W = 6,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] victim
);
  // age 0 = most recent, WAYS-1 = oldest
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + WAY_W'(1);
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[q_set][w] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
  end
endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2048,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wa_en,
  input  logic [AW-1:0]     wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [AW-1:0]     wb_addr,
  input  logic [DATA_W-1:0] wb_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wb_en) mem[wb_addr] <= wb_data;
    if (wa_en) mem[wa_addr] <= wa_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_all,
  input  logic              lock_en,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int OFF_W = $clog2(DATA_W/8);
  localparam int WRD_W = $clog2(LINE_WORDS);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W - WRD_W - OFF_W;
  localparam int DAW   = WAY_W + SET_W + WRD_W;
  localparam int DEPTH = WAYS * SETS * LINE_WORDS;

  logic [TAG_W-1:0] f_tag, w_tag, line_tag_q;
  logic [SET_W-1:0] f_set, w_set, line_set_q;
  logic [WRD_W-1:0] f_wrd, w_wrd, crit_q, cnt_q, cur_wrd;
  logic [WAY_W-1:0] vict_q, victim, lk_way, pw_way;
  logic             lk_hit, pw_hit;
  logic [DATA_W-1:0] rd_data;
  ic_state_e        state_q;
  logic             idle, hit_go, miss_go, fill_beat, fill_last, pass_beat;
  logic             unused_low;

  assign f_tag = fetch_addr[ADDR_W-1 -: TAG_W];
  assign f_set = fetch_addr[OFF_W+WRD_W +: SET_W];
  assign f_wrd = fetch_addr[OFF_W +: WRD_W];
  assign w_tag = wr_addr[ADDR_W-1 -: TAG_W];
  assign w_set = wr_addr[OFF_W+WRD_W +: SET_W];
  assign w_wrd = wr_addr[OFF_W +: WRD_W];
  assign unused_low = ^{fetch_addr[OFF_W-1:0], wr_addr[OFF_W-1:0]};

  assign idle      = (state_q == ST_IDLE);
  assign hit_go    = idle && fetch_req && lk_hit;
  assign miss_go   = idle && fetch_req && !lk_hit;
  assign cur_wrd   = crit_q + cnt_q;
  assign fill_beat = (state_q == ST_FILL) && mem_rvalid;
  assign fill_last = fill_beat && (cnt_q == WRD_W'(LINE_WORDS-1));
  assign pass_beat = (state_q == ST_PASS) && mem_rvalid;

  assign fetch_ready = hit_go || (fill_beat && cnt_q == '0) || pass_beat;
  assign fetch_rdata = hit_go ? rd_data : mem_rdata;
  assign mem_req     = !idle;
  assign mem_addr    = {line_tag_q, line_set_q, cur_wrd, {OFF_W{1'b0}}};

  icache_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_tags (
    .clk(clk), .rst(rst), .inv_all(inv_all),
    .lk_set(f_set), .lk_tag(f_tag), .lk_hit(lk_hit), .lk_way(lk_way),
    .pw_set(w_set), .pw_tag(w_tag), .pw_hit(pw_hit), .pw_way(pw_way),
    .clr_en(miss_go && !lock_en), .clr_way(victim), .clr_set(f_set),
    .fill_en(fill_last), .fill_way(vict_q), .fill_set(line_set_q), .fill_tag(line_tag_q)
  );

  icache_lru #(.WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(hit_go || fill_last),
    .touch_set(hit_go ? f_set : line_set_q),
    .touch_way(hit_go ? lk_way : vict_q),
    .q_set(f_set), .victim(victim)
  );

  icache_data #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(DAW)) u_data (
    .clk(clk),
    .rd_addr({lk_way, f_set, f_wrd}), .rd_data(rd_data),
    .wa_en(fill_beat), .wa_addr({vict_q, line_set_q, cur_wrd}), .wa_data(mem_rdata),
    .wb_en(wr_en && pw_hit), .wb_addr({pw_way, w_set, w_wrd}), .wb_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (miss_go) begin
          state_q <= lock_en ? ST_PASS : ST_FILL;
          cnt_q   <= '0;
        end
        ST_FILL: if (fill_beat) begin
          cnt_q <= cnt_q + WRD_W'(1);
          if (fill_last) state_q <= ST_IDLE;
        end
        ST_PASS: if (pass_beat) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (miss_go) begin
      line_tag_q <= f_tag;
      line_set_q <= f_set;
      crit_q     <= f_wrd;
      vict_q     <= victim;
    end
  end
endmodule

// File: rtl/icache_ctrl_chk.sv
module icache_ctrl_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req,
  input logic              fetch_ready,
  input logic [DATA_W-1:0] fetch_rdata,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(DATA_W/8);
  localparam int WRD_W = $clog2(LINE_WORDS);
  localparam int LSB   = OFF_W + WRD_W;
  localparam int BW    = $clog2(LINE_WORDS) + 1;

  logic [BW-1:0] beats_q;
  always_ff @(posedge clk) begin
    if (rst || !mem_req) beats_q <= '0;
    else if (mem_rvalid) beats_q <= beats_q + BW'(1);
  end

  assert_ready_has_req_R1: assert property (@(posedge clk) disable iff (rst)
    fetch_ready |-> fetch_req);

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  assert_wrap_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid) |=> (!mem_req ||
      ((mem_addr[ADDR_W-1:LSB] == $past(mem_addr[ADDR_W-1:LSB])) &&
       (mem_addr[OFF_W +: WRD_W] == WRD_W'($past(mem_addr[OFF_W +: WRD_W]) + 1'b1)))));

  assert_line_beats_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid) |-> (beats_q < BW'(LINE_WORDS)));

  assert_early_word_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_ready && mem_req) |-> (mem_rvalid && fetch_rdata == mem_rdata));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!mem_req && !fetch_ready));

  assert_hold_req_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
endmodule

bind icache_ctrl icache_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_ready(fetch_ready),
  .fetch_rdata(fetch_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
);

// File: tb/test_icache_ctrl.sv
module test_icache_ctrl;
  logic        clk = 1'b0;
  logic        rst, inv_all, lock_en, fetch_req, mem_rvalid, wr_en;
  logic [31:0] fetch_addr, mem_rdata, wr_addr, wr_data;
  logic        fetch_ready, mem_req;
  logic [31:0] fetch_rdata, mem_addr;

  icache_ctrl i_icache_ctrl (
    .clk(clk), .rst(rst), .inv_all(inv_all), .lock_en(lock_en),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .fetch_rdata(fetch_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int lat_cfg = 2, lat_cnt = 0;
  logic [31:0] exp_q[$];
  int unsigned mq[64][$];
  logic [31:0] mword[logic [31:0]];

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, a[31:16] + 16'h0101};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: memory responder then settle
  task automatic cyc();
    @(negedge clk);
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      lat_cnt = 0;
    end else if (mem_req) begin
      if (lat_cnt >= lat_cfg) begin
        mem_rvalid = 1'b1;
        mem_rdata = memfn(mem_addr);
        lat_cnt = 0;
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected memory read", mem_addr, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(mem_addr == e, "R2", "memory read order", mem_addr, e);
        end
      end else lat_cnt++;
    end
    #1;
  endtask

  function automatic int find(input int s, input int unsigned ln);
    for (int i = 0; i < mq[s].size(); i++) if (mq[s][i] == ln) return i;
    return -1;
  endfunction

  task automatic fetch(input logic [31:0] a, input string req,
                       input bit with_wr = 1'b0, input logic [31:0] wd = 32'h0);
    int unsigned ln;
    int s, idx, n;
    logic [31:0] wa;
    wa = {a[31:2], 2'b00};
    ln = a >> 5;
    s = int'((a >> 5) & 32'd63);
    idx = find(s, ln);
    fetch_req = 1'b1;
    fetch_addr = a;
    if (with_wr) begin wr_en = 1'b1; wr_addr = a; wr_data = wd; end
    #1;
    if (idx >= 0) begin
      chk(fetch_ready == 1'b1, req, "hit ready same cycle", {31'h0, fetch_ready}, 32'h1);
      chk(fetch_rdata == mword[wa], req, "hit data", fetch_rdata, mword[wa]);
      mq[s].delete(idx);
      mq[s].push_front(ln);
      cyc();
      fetch_req = 1'b0;
      wr_en = 1'b0;
      if (with_wr) mword[wa] = wd;
    end else begin
      chk(fetch_ready == 1'b0, req, "miss not ready at once", {31'h0, fetch_ready}, 32'h0);
      for (int w = 0; w < (lock_en ? 1 : 8); w++)
        exp_q.push_back({a[31:5], 3'(a[4:2] + 3'(w)), 2'b00});
      n = 0;
      while (!fetch_ready && n < 400) begin cyc(); n++; end
      chk(fetch_ready == 1'b1, req, "critical word ready", {31'h0, fetch_ready}, 32'h1);
      chk(fetch_rdata == memfn(wa), req, "critical word data", fetch_rdata, memfn(wa));
      cyc();
      fetch_req = 1'b0;
      wr_en = 1'b0;
      n = 0;
      while ((exp_q.size() != 0 || mem_req) && n < 400) begin cyc(); n++; end
      chk(exp_q.size() == 0, "R2", "all line reads issued", exp_q.size(), 0);
      exp_q.delete();
      if (!lock_en) begin
        if (mq[s].size() == 4) begin
          int unsigned old;
          old = mq[s].pop_back();
          for (int w = 0; w < 8; w++) mword.delete({old[26:0], 3'(w), 2'b00});
        end
        mq[s].push_front(ln);
        for (int w = 0; w < 8; w++) mword[{a[31:5], 3'(w), 2'b00}] = memfn({a[31:5], 3'(w), 2'b00});
      end
    end
    cyc();
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
    if (find(int'((a >> 5) & 32'd63), a >> 5) >= 0) mword[{a[31:2], 2'b00}] = d;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 32'h0, 32'h1);
    summary();
  end

  initial begin
    rst = 1'b1; inv_all = 1'b0; lock_en = 1'b0; fetch_req = 1'b0; fetch_addr = '0;
    mem_rvalid = 1'b0; mem_rdata = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk(mem_req == 1'b0, "R9", "mem_req after reset", {31'h0, mem_req}, 32'h0);
    chk(fetch_ready == 1'b0, "R9", "fetch_ready after reset", {31'h0, fetch_ready}, 32'h0);
    fetch(32'h0000_1000, "R9");

    // refill with critical word mid-line, then whole line hits
    fetch(32'h0000_2004, "R3");
    for (int w = 0; w < 8; w++) fetch(32'h0000_2000 + 32'(w*4), "R4");
    lat_cfg = 0;
    fetch(32'h0000_301C, "R2");
    fetch(32'h0000_3000, "R4");

    // LRU in set 5
    for (int t = 1; t <= 4; t++) fetch((32'(t) << 11) | 32'h0A0, "R5");
    fetch((32'd1 << 11) | 32'h0A4, "R5");
    fetch((32'd5 << 11) | 32'h0A0, "R5");
    fetch((32'd2 << 11) | 32'h0A0, "R5");
    fetch((32'd1 << 11) | 32'h0A8, "R5");
    fetch((32'd3 << 11) | 32'h0A0, "R5");
    lat_cfg = 1;

    // direct writes
    wr(32'h0000_2008, 32'hDEAD_BEEF);
    fetch(32'h0000_2008, "R7");
    wr(32'h0000_9000, 32'h1234_5678);
    fetch(32'h0000_9000, "R7");
    fetch(32'h0000_200C, "R7", 1'b1, 32'hCAFE_F00D);
    fetch(32'h0000_200C, "R7");

    // lock mode
    lock_en = 1'b1;
    fetch(32'h0000_2000, "R6");
    fetch(32'h0000_A010, "R6");
    fetch(32'h0000_A010, "R6");
    fetch((32'd5 << 11) | 32'h0A0, "R6");
    fetch((32'd6 << 11) | 32'h0A0, "R6");
    fetch((32'd1 << 11) | 32'h0A0, "R6");
    lock_en = 1'b0;

    // invalidate all
    inv_all = 1'b1;
    cyc();
    inv_all = 1'b0;
    for (int s = 0; s < 64; s++) mq[s].delete();
    mword.delete();
    fetch(32'h0000_2000, "R8");
    fetch(32'h0000_9000, "R8");
    fetch(32'h0000_2000, "R4");
    summary();
  end
endmodule